// File: doc/BRIEF.md
# SD Card Initialization Sequencer

This block is the host-side controller that takes an SD-protocol storage device from power-on to the data transfer state. It does not serialize anything itself. It sits in front of a separate command/response engine and tells that engine which command to send next: the index, the 32-bit argument, and a flag that marks application-specific commands. It then waits for the engine to hand back the response bits, a timeout flag and a CRC-error flag.

After reset the block first asks the engine for a run of idle clocks with the command line held high. It then resets the card and runs the operating-condition handshake: a probe with a zero argument, followed by polling with the voltage window the host supports. After that it fetches the identification, takes the relative address, selects the card and checks the card-type byte of the SD status. It then deselects the card, reads the CSD and CID again in standby, reselects the card and finally programs the bus width. Every application command gets its own CMD55 prefix, which carries the current relative address.

The outputs are a done flag, a fail flag with a reason code, and the captured OCR, RCA, CID and CSD values. All of these hold until the next reset.

Top module: `sd_init_seq`

## Requirements
- R1: During reset and for exactly WARMUP_CYCLES clocks after reset is released, `warmup_active` is high and `cmd_req` is low. The first command request follows one clock after `warmup_active` falls.
- R2: The first command is index 0 with argument 0. The timeout and CRC flags of its response are ignored.
- R3: Next comes CMD55 and then index 41 (app flag set) with argument 0. Polling with index 41 then repeats, each time with argument {8'h00, probe_window[23:0] & VDD_MASK}, until response bit 31 is 1. The captured response is shown on `ocr`. The CRC flag is ignored on responses to index 41.
- R4: The block stops with fail code 1 (not an SD card) in three cases: a timeout on index 41, a timeout on the CMD55 that precedes it, or `poll_limit` busy poll responses in a row. A limit of 0 or 1 allows one poll.
- R5: Index 2 captures `cid` from rsp_data[127:0]. Index 3 captures `rca` from rsp_data[31:16]. A zero RCA stops the block with fail code 4, and `done` never rises with `rca` equal to 0.
- R6: Index 7 with argument {rca,16'h0} selects the card. If `acmd42_en` is 1, the next step is CMD55 followed by index 42 (app) with argument 0. Otherwise that step is skipped.
- R7: Index 13 (app, argument 0) reads the status. A nonzero rsp_data[127:120] stops the block with fail code 5.
- R8: The steps that follow, in order, are: index 7 with argument 0 (its flags are ignored), index 9 with argument {rca,16'h0} (captures `csd`), index 10 with argument {rca,16'h0} (replaces `cid`), index 7 with argument {rca,16'h0}, then CMD55 and index 6 (app) with argument 2 when `bus_wide` is 1 or 0 when it is 0. After that, `done` rises.
- R9: Outside the operating-condition phase, a timeout gives fail code 2 and a CRC error gives fail code 3. When both flags are set, the timeout wins. A failing CMD55 is reported in the same way.
- R10: `done` and `fail` are never high together. Both hold until reset, and `cmd_req` stays low once either is high. `fail_code` is 0 whenever `fail` is low.
- R11: Every command with the app flag set is directly preceded by index 55 with argument {rca,16'h0}, where rca is 0 until it has been captured.
- R12: While `cmd_req` is high and no response has arrived, index, argument and app flag stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acmd42_en | input | 1 | Insert the pull-up disconnect step after selection |
| bus_wide | input | 1 | 1 selects the four-line bus, 0 the single line |
| poll_limit | input | 16 | Maximum number of operating-condition polls |
| warmup_active | output | 1 | Engine should send idle clocks with CMD high |
| cmd_req | output | 1 | A command is requested |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_app | output | 1 | Command is application-specific |
| rsp_valid | input | 1 | One-cycle completion of the requested command |
| rsp_data | input | 128 | Response bits; short responses use [31:0] |
| rsp_timeout | input | 1 | No response was received |
| rsp_crc_err | input | 1 | Response CRC mismatch |
| done | output | 1 | Card is in transfer state with bus width set |
| fail | output | 1 | Initialization aborted |
| fail_code | output | 3 | 0 none, 1 not SD, 2 timeout, 3 CRC, 4 zero RCA, 5 card type |
| ocr | output | 32 | Last operating-condition response |
| rca | output | 16 | Relative card address |
| cid | output | 128 | Card identification |
| csd | output | 128 | Card-specific data |

## Verification
Two things can land on the same response: the timeout flag and the CRC-error flag. The bench injects both on the CSD read and expects the timeout code, not the CRC code. A second case involves the CRC flag arriving on a poll response that also reports the card ready. The block has to drop that CRC flag and still take the ready bit, so the bench sets the CRC flag on every operating-condition response of a full run and expects `done` with the complete command sequence.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

    localparam int IDX_W  = 6;
    localparam int ARG_W  = 32;
    localparam int LONG_W = 128;
    localparam int RCA_W  = 16;
    localparam int WIN_W  = 24;

    localparam logic [IDX_W-1:0] IX_RESET    = 6'd0;
    localparam logic [IDX_W-1:0] IX_ALL_ID   = 6'd2;
    localparam logic [IDX_W-1:0] IX_ADDR     = 6'd3;
    localparam logic [IDX_W-1:0] IX_SELECT   = 6'd7;
    localparam logic [IDX_W-1:0] IX_CSD      = 6'd9;
    localparam logic [IDX_W-1:0] IX_CID      = 6'd10;
    localparam logic [IDX_W-1:0] IX_APP_PFX  = 6'd55;
    localparam logic [IDX_W-1:0] IX_OPCOND   = 6'd41;
    localparam logic [IDX_W-1:0] IX_PULLUP   = 6'd42;
    localparam logic [IDX_W-1:0] IX_STATUS   = 6'd13;
    localparam logic [IDX_W-1:0] IX_WIDTH    = 6'd6;

    typedef enum logic [4:0] {
        ST_WARM, ST_RESET, ST_PROBE, ST_POLL, ST_ALL_ID, ST_ADDR,
        ST_SELECT, ST_PULLUP, ST_STATUS, ST_DESELECT, ST_RD_CSD,
        ST_RD_CID, ST_RESELECT, ST_WIDTH, ST_DONE, ST_FAIL
    } step_e;

    typedef enum logic [2:0] {
        FL_NONE     = 3'd0,
        FL_NOT_SD   = 3'd1,
        FL_TIMEOUT  = 3'd2,
        FL_CRC      = 3'd3,
        FL_BAD_RCA  = 3'd4,
        FL_BAD_TYPE = 3'd5
    } fail_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [ARG_W-1:0] arg;
        logic             app;
    } sd_cmd_t;

    function automatic logic needs_app(step_e s);
        return (s == ST_PROBE) || (s == ST_POLL) || (s == ST_PULLUP) ||
               (s == ST_STATUS) || (s == ST_WIDTH);
    endfunction

    function automatic logic in_opcond(step_e s);
        return (s == ST_PROBE) || (s == ST_POLL);
    endfunction

    function automatic logic flags_ignored(step_e s);
        return (s == ST_RESET) || (s == ST_DESELECT);
    endfunction

    function automatic logic is_issuing(step_e s);
        return !((s == ST_WARM) || (s == ST_DONE) || (s == ST_FAIL));
    endfunction

    function automatic step_e step_after(step_e s, logic pullup_off);
        step_e n;
        case (s)
            ST_WARM:     n = ST_RESET;
            ST_RESET:    n = ST_PROBE;
            ST_PROBE:    n = ST_POLL;
            ST_POLL:     n = ST_ALL_ID;
            ST_ALL_ID:   n = ST_ADDR;
            ST_ADDR:     n = ST_SELECT;
            ST_SELECT:   n = pullup_off ? ST_PULLUP : ST_STATUS;
            ST_PULLUP:   n = ST_STATUS;
            ST_STATUS:   n = ST_DESELECT;
            ST_DESELECT: n = ST_RD_CSD;
            ST_RD_CSD:   n = ST_RD_CID;
            ST_RD_CID:   n = ST_RESELECT;
            ST_RESELECT: n = ST_WIDTH;
            ST_WIDTH:    n = ST_DONE;
            default:     n = s;
        endcase
        return n;
    endfunction

    function automatic sd_cmd_t build_cmd(step_e s, logic prefix,
                                          logic [RCA_W-1:0] rca,
                                          logic [WIN_W-1:0] win,
                                          logic wide);
        sd_cmd_t c;
        logic [ARG_W-1:0] addr_arg;
        addr_arg = {rca, {(ARG_W-RCA_W){1'b0}}};
        c = '{idx: IX_RESET, arg: '0, app: 1'b0};
        if (prefix) begin
            c.idx = IX_APP_PFX;
            c.arg = addr_arg;
        end else begin
            c.app = needs_app(s);
            case (s)
                ST_PROBE:    c.idx = IX_OPCOND;
                ST_POLL:     begin c.idx = IX_OPCOND; c.arg = {{(ARG_W-WIN_W){1'b0}}, win}; end
                ST_ALL_ID:   c.idx = IX_ALL_ID;
                ST_ADDR:     c.idx = IX_ADDR;
                ST_SELECT:   begin c.idx = IX_SELECT; c.arg = addr_arg; end
                ST_PULLUP:   c.idx = IX_PULLUP;
                ST_STATUS:   c.idx = IX_STATUS;
                ST_DESELECT: c.idx = IX_SELECT;
                ST_RD_CSD:   begin c.idx = IX_CSD; c.arg = addr_arg; end
                ST_RD_CID:   begin c.idx = IX_CID; c.arg = addr_arg; end
                ST_RESELECT: begin c.idx = IX_SELECT; c.arg = addr_arg; end
                ST_WIDTH:    begin c.idx = IX_WIDTH; c.arg = wide ? 32'd2 : 32'd0; end
                default:     c.idx = IX_RESET;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sd_warmup.sv
module sd_warmup #(
    parameter int CYCLES = 80
) (
    input  logic clk,
    input  logic rst,
    output logic active
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES);

    logic [CW-1:0] cnt;

    assign active = (cnt != LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (active)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sd_poll_budget.sv
module sd_poll_budget #(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              bump,
    input  logic [POLL_W-1:0] limit,
    output logic              last
);
    logic [POLL_W-1:0] cnt;
    logic [POLL_W:0]   next_total;

    assign next_total = {1'b0, cnt} + {{POLL_W{1'b0}}, 1'b1};
    assign last       = next_total >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (bump && (cnt != '1))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sd_reg_capture.sv
module sd_reg_capture
    import sd_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  step_e             step,
    input  logic [LONG_W-1:0] rsp_data,
    output logic [ARG_W-1:0]  ocr,
    output logic [RCA_W-1:0]  rca,
    output logic [WIN_W-1:0]  win,
    output logic [LONG_W-1:0] cid,
    output logic [LONG_W-1:0] csd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ocr <= '0;
            rca <= '0;
            win <= '0;
            cid <= '0;
            csd <= '0;
        end else if (accept) begin
            case (step)
                ST_PROBE:  win <= rsp_data[WIN_W-1:0];
                ST_POLL:   ocr <= rsp_data[ARG_W-1:0];
                ST_ALL_ID,
                ST_RD_CID: cid <= rsp_data;
                ST_ADDR:   rca <= rsp_data[ARG_W-1:ARG_W-RCA_W];
                ST_RD_CSD: csd <= rsp_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sd_init_fsm.sv
module sd_init_fsm
    import sd_init_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  warm_done,
    input  logic  pullup_off,
    input  logic  rsp_valid,
    input  logic  rsp_timeout,
    input  logic  rsp_crc_err,
    input  logic  rsp_ready,
    input  logic  rsp_rca_zero,
    input  logic  rsp_type_bad,
    input  logic  poll_last,
    output step_e step,
    output logic  prefix,
    output fail_e fail_why,
    output logic  accept,
    output logic  poll_clear,
    output logic  poll_bump
);
    step_e nxt_step;
    step_e adv;
    logic  nxt_pre;
    fail_e nxt_fail;
    fail_e to_code;

    always_comb begin
        adv      = step_after(step, pullup_off);
        to_code  = in_opcond(step) ? FL_NOT_SD : FL_TIMEOUT;
        nxt_step = step;
        nxt_pre  = prefix;
        nxt_fail = fail_why;
        accept     = 1'b0;
        poll_clear = 1'b0;
        poll_bump  = 1'b0;
        if (step == ST_WARM) begin
            if (warm_done) begin
                nxt_step = ST_RESET;
                nxt_pre  = 1'b0;
            end
        end else if (is_issuing(step) && rsp_valid) begin
            if (prefix) begin
                if (rsp_timeout) begin
                    nxt_step = ST_FAIL;
                    nxt_fail = to_code;
                end else if (rsp_crc_err) begin
                    nxt_step = ST_FAIL;
                    nxt_fail = FL_CRC;
                end else begin
                    nxt_pre = 1'b0;
                end
            end else if (!flags_ignored(step) && rsp_timeout) begin
                nxt_step = ST_FAIL;
                nxt_fail = to_code;
            end else if (!flags_ignored(step) && !in_opcond(step) && rsp_crc_err) begin
                nxt_step = ST_FAIL;
                nxt_fail = FL_CRC;
            end else begin
                accept = 1'b1;
                case (step)
                    ST_PROBE: begin
                        nxt_step   = adv;
                        nxt_pre    = 1'b1;
                        poll_clear = 1'b1;
                    end
                    ST_POLL: begin
                        if (rsp_ready) begin
                            nxt_step = adv;
                            nxt_pre  = needs_app(adv);
                        end else if (poll_last) begin
                            nxt_step = ST_FAIL;
                            nxt_fail = FL_NOT_SD;
                        end else begin
                            nxt_pre   = 1'b1;
                            poll_bump = 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        if (rsp_rca_zero) begin
                            nxt_step = ST_FAIL;
                            nxt_fail = FL_BAD_RCA;
                        end else begin
                            nxt_step = adv;
                            nxt_pre  = needs_app(adv);
                        end
                    end
                    ST_STATUS: begin
                        if (rsp_type_bad) begin
                            nxt_step = ST_FAIL;
                            nxt_fail = FL_BAD_TYPE;
                        end else begin
                            nxt_step = adv;
                            nxt_pre  = needs_app(adv);
                        end
                    end
                    default: begin
                        nxt_step = adv;
                        nxt_pre  = needs_app(adv);
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step     <= ST_WARM;
            prefix   <= 1'b0;
            fail_why <= FL_NONE;
        end else begin
            step     <= nxt_step;
            prefix   <= nxt_pre;
            fail_why <= nxt_fail;
        end
    end
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
    import sd_init_pkg::*;
#(
    parameter int               WARMUP_CYCLES = 80,
    parameter int               POLL_W        = 16,
    parameter logic [23:0]      VDD_MASK      = 24'hFF8000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acmd42_en,
    input  logic                bus_wide,
    input  logic [POLL_W-1:0]   poll_limit,
    output logic                warmup_active,
    output logic                cmd_req,
    output logic [5:0]          cmd_idx,
    output logic [31:0]         cmd_arg,
    output logic                cmd_app,
    input  logic                rsp_valid,
    input  logic [127:0]        rsp_data,
    input  logic                rsp_timeout,
    input  logic                rsp_crc_err,
    output logic                done,
    output logic                fail,
    output logic [2:0]          fail_code,
    output logic [31:0]         ocr,
    output logic [15:0]         rca,
    output logic [127:0]        cid,
    output logic [127:0]        csd
);
    step_e   step;
    logic    prefix;
    fail_e   fail_why;
    logic    accept;
    logic    poll_clear;
    logic    poll_bump;
    logic    poll_last;
    logic    [WIN_W-1:0] win;
    sd_cmd_t cmd_now;

    sd_warmup #(.CYCLES(WARMUP_CYCLES)) u_warm (
        .clk    (clk),
        .rst    (rst),
        .active (warmup_active)
    );

    sd_poll_budget #(.POLL_W(POLL_W)) u_budget (
        .clk   (clk),
        .rst   (rst),
        .clear (poll_clear),
        .bump  (poll_bump),
        .limit (poll_limit),
        .last  (poll_last)
    );

    sd_init_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .warm_done    (!warmup_active),
        .pullup_off   (acmd42_en),
        .rsp_valid    (rsp_valid),
        .rsp_timeout  (rsp_timeout),
        .rsp_crc_err  (rsp_crc_err),
        .rsp_ready    (rsp_data[ARG_W-1]),
        .rsp_rca_zero (rsp_data[ARG_W-1:ARG_W-RCA_W] == '0),
        .rsp_type_bad (|rsp_data[LONG_W-1:LONG_W-8]),
        .poll_last    (poll_last),
        .step         (step),
        .prefix       (prefix),
        .fail_why     (fail_why),
        .accept       (accept),
        .poll_clear   (poll_clear),
        .poll_bump    (poll_bump)
    );

    sd_reg_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .step     (step),
        .rsp_data (rsp_data),
        .ocr      (ocr),
        .rca      (rca),
        .win      (win),
        .cid      (cid),
        .csd      (csd)
    );

    always_comb begin
        cmd_now = build_cmd(step, prefix, rca, win & VDD_MASK, bus_wide);
    end

    assign cmd_req   = is_issuing(step);
    assign cmd_idx   = cmd_now.idx;
    assign cmd_arg   = cmd_now.arg;
    assign cmd_app   = cmd_now.app;
    assign done      = (step == ST_DONE);
    assign fail      = (step == ST_FAIL);
    assign fail_code = fail_why;
endmodule

// File: rtl/sd_init_seq_chk.sv
module sd_init_seq_chk (
    input logic         clk,
    input logic         rst,
    input logic         warmup_active,
    input logic         cmd_req,
    input logic [5:0]   cmd_idx,
    input logic [31:0]  cmd_arg,
    input logic         cmd_app,
    input logic         rsp_valid,
    input logic [127:0] rsp_data,
    input logic         rsp_timeout,
    input logic         rsp_crc_err,
    input logic         done,
    input logic         fail,
    input logic [2:0]   fail_code,
    input logic [15:0]  rca
);
    AST_WARM_QUIET: assert property (@(posedge clk) disable iff (rst)
        warmup_active |-> !cmd_req); // R1

    AST_RESET_FIRST: assert property (@(posedge clk) disable iff (rst)
        $fell(warmup_active) |=> (cmd_req && cmd_idx == 6'd0 && cmd_arg == 32'd0)); // R2

    AST_BAD_RCA_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (rca != 16'd0)); // R5

    AST_TYPE_REJECT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && cmd_req && cmd_app && cmd_idx == 6'd13 && !rsp_timeout &&
         !rsp_crc_err && rsp_data[127:120] != 8'd0) |=> (fail && fail_code == 3'd5)); // R7

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && !cmd_req)); // R10

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (rst)
        fail |=> (fail && !cmd_req && $stable(fail_code))); // R10

    AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && fail) && (fail || fail_code == 3'd0)); // R10

    AST_APP_AFTER_PFX: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && cmd_req && cmd_idx == 6'd55 && !rsp_timeout && !rsp_crc_err)
        |=> (cmd_req && cmd_app)); // R11

    AST_PFX_ARG: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_idx == 6'd55) |-> (cmd_arg == {rca, 16'h0000} && !cmd_app)); // R11

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !rsp_valid) |=> (cmd_req && $stable(cmd_idx) &&
                                     $stable(cmd_arg) && $stable(cmd_app))); // R12
endmodule

bind sd_init_seq sd_init_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .warmup_active (warmup_active),
    .cmd_req       (cmd_req),
    .cmd_idx       (cmd_idx),
    .cmd_arg       (cmd_arg),
    .cmd_app       (cmd_app),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data),
    .rsp_timeout   (rsp_timeout),
    .rsp_crc_err   (rsp_crc_err),
    .done          (done),
    .fail          (fail),
    .fail_code     (fail_code),
    .rca           (rca)
);

// File: tb/tb_sd_init_seq.sv
`timescale 1ns/1ps
module tb_sd_init_seq;
    localparam int          W        = 80;
    localparam logic [23:0] WIN      = 24'hFF8F00;
    localparam logic [31:0] POLL_ARG = 32'h00FF8000; // WIN masked by 24'hFF8000
    localparam logic [127:0] CID_A   = 128'h11223344_55667788_99AABBCC_DDEEFF01;
    localparam logic [127:0] CID_B   = 128'hA5A5A5A5_0F0F0F0F_12345678_9ABCDEF1;
    localparam logic [127:0] CSD_V   = 128'h400E0032_5B590000_39B77F80_0A400001;

    logic clk = 0;
    logic rst = 1;
    logic acmd42_en = 0, bus_wide = 1;
    logic [15:0] poll_limit = 16'd20;
    logic warmup_active, cmd_req, cmd_app, done, fail;
    logic [5:0] cmd_idx;
    logic [31:0] cmd_arg, ocr;
    logic rsp_valid = 0, rsp_timeout = 0, rsp_crc_err = 0;
    logic [127:0] rsp_data = '0;
    logic [2:0] fail_code;
    logic [15:0] rca;
    logic [127:0] cid, csd;

    always #2.5 clk = ~clk;

    sd_init_seq dut (
        .clk(clk), .rst(rst), .acmd42_en(acmd42_en), .bus_wide(bus_wide),
        .poll_limit(poll_limit), .warmup_active(warmup_active), .cmd_req(cmd_req),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_app(cmd_app),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout),
        .rsp_crc_err(rsp_crc_err), .done(done), .fail(fail), .fail_code(fail_code),
        .ocr(ocr), .rca(rca), .cid(cid), .csd(csd)
    );

    int checks = 0, errors = 0;

    // card model state
    int n_log, polls_seen, busy_polls, fault_seq, hold_bad, k_cur;
    bit fault_to, fault_crc, crc_on_41;
    logic [15:0] rca_val;
    logic [7:0]  type_val;
    logic [5:0]  log_idx [40];
    logic [31:0] log_arg [40];
    logic        log_app [40];
    logic [5:0]  c_idx;
    logic [31:0] c_arg;
    logic        c_app;

    int n_exp;
    logic [5:0]  exp_idx [40];
    logic [31:0] exp_arg [40];
    logic        exp_app [40];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // command/response engine model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cmd_req) begin
                k_cur = n_log;
                c_idx = cmd_idx; c_arg = cmd_arg; c_app = cmd_app;
                if (n_log < 40) begin
                    log_idx[n_log] = c_idx; log_arg[n_log] = c_arg; log_app[n_log] = c_app;
                end
                n_log++;
                repeat (2) begin
                    @(negedge clk);
                    if (!cmd_req || cmd_idx != c_idx || cmd_arg != c_arg || cmd_app != c_app)
                        hold_bad++;
                end
                rsp_data = 128'h900;
                if (c_idx == 6'd55) rsp_data = 128'h120;
                else if (c_idx == 6'd41 && c_app) begin
                    if (c_arg == 32'd0) rsp_data = {96'h0, 8'h00, WIN};
                    else begin
                        rsp_data = {96'h0, (polls_seen >= busy_polls), 7'h0, WIN};
                        polls_seen++;
                    end
                end
                else if (c_idx == 6'd2)  rsp_data = CID_A;
                else if (c_idx == 6'd3)  rsp_data = {96'h0, rca_val, 16'h0500};
                else if (c_idx == 6'd13 && c_app) rsp_data = {type_val, 120'h0};
                else if (c_idx == 6'd9)  rsp_data = CSD_V;
                else if (c_idx == 6'd10) rsp_data = CID_B;
                rsp_timeout = (k_cur == fault_seq) && fault_to;
                rsp_crc_err = ((k_cur == fault_seq) && fault_crc) ||
                              (crc_on_41 && c_idx == 6'd41 && c_app);
                rsp_valid = 1;
                @(negedge clk);
                rsp_valid = 0; rsp_timeout = 0; rsp_crc_err = 0; rsp_data = '0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic do_reset(input bit check_state);
        int n;
        @(negedge clk);
        rst = 1;
        n_log = 0; polls_seen = 0; busy_polls = 2; fault_seq = -1; hold_bad = 0;
        fault_to = 0; fault_crc = 0; crc_on_41 = 0; rca_val = 16'hB0A7; type_val = 8'h00;
        repeat (3) @(negedge clk);
        if (check_state) begin
            chk(!done && !fail && fail_code == 0 && !cmd_req, "R10", "reset state",
                {done, fail, fail_code, cmd_req}, 0);
            chk(warmup_active && rca == 0 && cid == 0, "R1", "reset outputs",
                {warmup_active, rca}, {1'b1, 16'h0});
        end
        rst = 0;
        n = 0;
        while (warmup_active && n < 1000) begin
            if (cmd_req) hold_bad = hold_bad + 100;
            n++;
            @(negedge clk);
        end
        if (check_state) chk(n == W && hold_bad == 0, "R1", "warmup length", n, W);
    endtask

    task automatic wait_end();
        int n = 0;
        while (!(done || fail) && n < 4000) begin @(negedge clk); n++; end
        repeat (20) @(negedge clk);
    endtask

    task automatic push(input logic [5:0] i, input logic [31:0] a, input logic p);
        exp_idx[n_exp] = i; exp_arg[n_exp] = a; exp_app[n_exp] = p; n_exp++;
    endtask

    task automatic build_exp(input bit a42, input bit wide, input int busy);
        logic [31:0] ra = {rca_val, 16'h0};
        n_exp = 0;
        push(0, 0, 0); push(55, 0, 0); push(41, 0, 1);
        for (int i = 0; i <= busy; i++) begin push(55, 0, 0); push(41, POLL_ARG, 1); end
        push(2, 0, 0); push(3, 0, 0); push(7, ra, 0);
        if (a42) begin push(55, ra, 0); push(42, 0, 1); end
        push(55, ra, 0); push(13, 0, 1); push(7, 0, 0); push(9, ra, 0);
        push(10, ra, 0); push(7, ra, 0); push(55, ra, 0); push(6, wide ? 32'd2 : 32'd0, 1);
    endtask

    task automatic cmp_log(input string req);
        chk(n_log == n_exp, req, "command count", n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++)
            chk(log_idx[i] == exp_idx[i] && log_arg[i] == exp_arg[i] && log_app[i] == exp_app[i],
                req, $sformatf("command %0d", i),
                {log_idx[i], log_arg[i], log_app[i]}, {exp_idx[i], exp_arg[i], exp_app[i]});
    endtask

    task automatic t_nominal();
        acmd42_en = 0; bus_wide = 1; poll_limit = 16'd20;
        do_reset(1);
        wait_end();
        chk(n_log > 0 && log_idx[0] == 0 && log_arg[0] == 0, "R2", "first command",
            {log_idx[0], log_arg[0]}, 0);
        build_exp(0, 1, 2);
        cmp_log("R3 R6 R8 R11");
        chk(done && !fail && fail_code == 0, "R8", "done", {done, fail, fail_code}, 5'b10000);
        chk(ocr == {1'b1, 7'h0, WIN}, "R3", "ocr", ocr, {1'b1, 7'h0, WIN});
        chk(rca == rca_val, "R5", "rca", rca, rca_val);
        chk(cid == CID_B, "R8", "cid replaced", cid, CID_B);
        chk(csd == CSD_V, "R8", "csd", csd, CSD_V);
        chk(!cmd_req, "R10", "quiet after done", cmd_req, 0);
        chk(hold_bad == 0, "R12", "request stable", hold_bad, 0);
    endtask

    task automatic t_pullup_narrow_crc41();
        acmd42_en = 1; bus_wide = 0; poll_limit = 16'd20;
        do_reset(0);
        crc_on_41 = 1; busy_polls = 1;
        wait_end();
        build_exp(1, 0, 1);
        cmp_log("R6 R3");
        chk(done && fail_code == 0, "R3", "crc ignored on opcond", fail_code, 0);
    endtask

    task automatic t_fault(input string req, input int seq, input bit to, input bit crc,
                           input int exp_code, input int exp_n, input bit exp_done);
        acmd42_en = 0; bus_wide = 1; poll_limit = 16'd20;
        do_reset(0);
        fault_seq = seq; fault_to = to; fault_crc = crc;
        wait_end();
        chk(done == exp_done && fail == !exp_done && fail_code == exp_code, req,
            $sformatf("fault at %0d", seq), {done, fail, fail_code}, {exp_done, !exp_done, 3'(exp_code)});
        chk(n_log == exp_n, req, "commands issued", n_log, exp_n);
    endtask

    task automatic t_retry_limit();
        acmd42_en = 0; poll_limit = 16'd3;
        do_reset(0);
        busy_polls = 10;
        wait_end();
        chk(fail && fail_code == 1, "R4", "poll limit", fail_code, 1);
        chk(n_log == 9, "R4", "poll count", n_log, 9);
    endtask

    task automatic t_rca_zero();
        poll_limit = 16'd20;
        do_reset(0);
        rca_val = 16'h0000;
        wait_end();
        chk(fail && fail_code == 4 && !done, "R5", "zero rca", fail_code, 4);
        chk(n_log == 11, "R5", "stop after addr", n_log, 11);
    endtask

    task automatic t_card_type();
        poll_limit = 16'd20; acmd42_en = 0;
        do_reset(0);
        type_val = 8'h01;
        wait_end();
        chk(fail && fail_code == 5, "R7", "card type", fail_code, 5);
        chk(n_log == 14, "R7", "stop after status", n_log, 14);
    endtask

    initial begin
        t_nominal();
        t_pullup_narrow_crc41();
        t_fault("R4", 4, 1, 0, 1, 5, 0);    // timeout on poll
        t_fault("R4", 3, 1, 0, 1, 4, 0);    // timeout on prefix of poll
        t_retry_limit();
        t_rca_zero();
        t_card_type();
        t_fault("R9", 15, 1, 1, 2, 16, 0);  // timeout and crc together on CSD read
        t_fault("R9", 9, 0, 1, 3, 10, 0);   // crc on CID fetch
        t_fault("R9", 12, 1, 0, 2, 13, 0);  // prefix before status read
        t_fault("R8", 14, 1, 1, 0, 20, 1);  // deselect flags ignored
        t_fault("R2", 0, 1, 1, 0, 20, 1);   // reset command flags ignored
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule